// File: doc/BRIEF.md
# Half-Pel Motion Compensation Predictor

This block forms an 8x8 prediction block of 8-bit pixels from a reference area for a video decoder. A request selects one of four prediction modes: integer copy, horizontal half-pel, vertical half-pel, or diagonal half-pel (horizontal and vertical together). A rounding-control bit chooses between the two rounding constants used by the averaging steps. Reference rows arrive already byte-aligned over a valid/ready handshake. Each beat carries one row of pixels plus the same row shifted one pixel to the right, so every lane sees a pixel and its right neighbour.

All lanes work in parallel. Each accepted row that completes an output row produces that row on the following cycle, marked by `out_valid`. The vertical and diagonal modes need one extra reference row. The first row of those modes is only stored, and every later row is paired with the stored one, so no reference row is fetched twice. In the diagonal mode, the half-sum and the low XOR bit of each horizontal pixel pair are kept, so the next output row does not compute them again. A one-cycle `done` pulse follows the last row. Address generation, alignment and residual addition belong to the surrounding logic.

Top module: `hpel_predictor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid`, `done`, `busy` and `in_ready` are all 0.
- R2: `start` is taken only while `busy` is 0. Taking it raises `busy` and samples `mode` and `rnd_off`. A `start` pulse while busy has no effect. `in_ready` is 1 only while the block still needs reference rows for the current request.
- R3: Mode encoding is 0 integer copy, 1 horizontal, 2 vertical, 3 diagonal. Pixels are packed with lane i in bits [8i+7:8i], and `in_row_sh` lane i holds reference pixel column i+1. In mode 0, output lane i equals input lane i of the same beat, whatever the value of `rnd_off`.
- R4: In mode 1, output lane i is (p + q + 1 - r) >> 1. Here p and q are lane i of `in_row` and `in_row_sh`, and r is the sampled `rnd_off` (0 = round, 1 = no rounding).
- R5: In mode 2, the first accepted row produces no output. Output row k is (u + v + 1 - r) >> 1 per lane, where u comes from reference row k and v from reference row k+1.
- R6: In mode 3, output row k lane i is (a + b + c + d + 2 - r) >> 2. Here a and b are columns i and i+1 of reference row k, and c and d are the same columns of row k+1. The result is exact for all 8-bit values, including all-255 input.
- R7: Each request yields exactly 8 output rows. `out_valid` is high only in the cycle after an input beat was accepted. Modes 0 and 1 accept 8 rows, and modes 2 and 3 accept 9 rows.
- R8: `done` is high for exactly one cycle, in the cycle after the last `out_valid`. `busy` is 0 in that same cycle.
- R9: A cycle with `in_valid` low consumes no row and is followed by a cycle with `out_valid` low.
- R10: Changes on `mode` or `rnd_off` after a request is taken do not alter that request's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (taken when idle) |
| mode | input | 2 | Prediction mode, sampled on start |
| rnd_off | input | 1 | Rounding control, 0 = round, 1 = no rounding |
| in_valid | input | 1 | Reference row beat present |
| in_ready | output | 1 | Block accepts a reference row |
| in_row | input | LANES*PIX_W | Reference row, columns 0..LANES-1 |
| in_row_sh | input | LANES*PIX_W | Same row shifted right by one pixel, columns 1..LANES |
| out_valid | output | 1 | Output row present |
| out_row | output | LANES*PIX_W | Predicted row |
| done | output | 1 | One-cycle pulse after the final row |
| busy | output | 1 | A request is in progress |

## Verification
The bench builds the block with its defaults: 8 lanes, 8 rows and 8-bit pixels. These values give a full 8x8 block with the 9-column and 9-row reference span that the half-pel modes need. They also let all-255 and all-0 areas test the widest diagonal sum and the rounding constant at both ends of the pixel range. Every mode is run with both rounding settings, with and without input stalls. Some runs also change `mode`, `rnd_off` and `start` in the middle of a request.

// File: rtl/hpel_pkg.sv
package hpel_pkg;
  typedef enum logic [1:0] {
    MODE_COPY   = 2'd0,
    MODE_HALF_H = 2'd1,
    MODE_HALF_V = 2'd2,
    MODE_HALF_D = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROWS  = 2'd1,
    ST_FLUSH = 2'd2
  } state_e;
endpackage

// File: rtl/hpel_lane.sv
module hpel_lane
  import hpel_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  mode_e            mode,
  input  logic             rc,
  input  logic [PIX_W-1:0] cur_p,
  input  logic [PIX_W-1:0] cur_q,
  input  logic [PIX_W-1:0] prev_p,
  input  logic [PIX_W-1:0] prev_hs,
  input  logic             prev_lsb,
  output logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] hs,
  output logic             lsb
);
  localparam int SW = PIX_W + 3;

  logic [SW-1:0] rnd1;
  logic [SW-1:0] sum_h;
  logic [SW-1:0] sum_v;
  logic [SW-1:0] sum_pair;
  logic [SW-1:0] sum_d;

  assign rnd1     = {{(SW-1){1'b0}}, ~rc};
  assign sum_pair = SW'(cur_p) + SW'(cur_q);
  assign hs       = PIX_W'(sum_pair >> 1);
  assign lsb      = cur_p[0] ^ cur_q[0];
  assign sum_h    = sum_pair + rnd1;
  assign sum_v    = SW'(prev_p) + SW'(cur_p) + rnd1;
  // 2*hs + lsb rebuilds a pair sum; the stored pair comes from the previous row
  assign sum_d    = (SW'(prev_hs) << 1) + SW'(prev_lsb) + (SW'(hs) << 1)
                  + SW'(lsb) + SW'(2) - SW'(rc);

  always_comb begin
    unique case (mode)
      MODE_COPY:   pix = cur_p;
      MODE_HALF_H: pix = PIX_W'(sum_h >> 1);
      MODE_HALF_V: pix = PIX_W'(sum_v >> 1);
      default:     pix = PIX_W'(sum_d >> 2);
    endcase
  end
endmodule

// File: rtl/hpel_ctrl.sv
module hpel_ctrl
  import hpel_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] mode_in,
  input  logic       rc_in,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       accept,
  output logic       emit,
  output logic       busy,
  output logic       done,
  output mode_e      mode_q,
  output logic       rc_q
);
  localparam int CW = $clog2(ROWS + 2);

  state_e         st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  need;
  logic           two_row;

  assign two_row  = (mode_q == MODE_HALF_V) || (mode_q == MODE_HALF_D);
  assign need     = two_row ? CW'(ROWS + 1) : CW'(ROWS);
  assign in_ready = (st == ST_ROWS);
  assign accept   = in_ready && in_valid;
  assign emit     = accept && !(two_row && (cnt == '0));
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_q <= MODE_COPY;
      rc_q   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_ROWS;
            cnt    <= '0;
            mode_q <= mode_e'(mode_in);
            rc_q   <= rc_in;
          end
        end
        ST_ROWS: begin
          if (accept) begin
            cnt <= cnt + 1'b1;
            if (cnt == need - 1'b1) st <= ST_FLUSH;
          end
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/hpel_predictor.sv
module hpel_predictor
  import hpel_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ROWS  = 8,
  parameter int PIX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic                   rnd_off,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_row,
  input  logic [LANES*PIX_W-1:0] in_row_sh,
  output logic                   out_valid,
  output logic [LANES*PIX_W-1:0] out_row,
  output logic                   done,
  output logic                   busy
);
  localparam int RW = LANES * PIX_W;

  logic            accept;
  logic            emit;
  mode_e           mode_q;
  logic            rc_q;
  logic [RW-1:0]   next_row;

  hpel_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode_in  (mode),
    .rc_in    (rnd_off),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .emit     (emit),
    .busy     (busy),
    .done     (done),
    .mode_q   (mode_q),
    .rc_q     (rc_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PIX_W-1:0] prev_p;
    logic [PIX_W-1:0] prev_hs;
    logic             prev_lsb;
    logic [PIX_W-1:0] hs;
    logic             lsb;
    logic [PIX_W-1:0] pix;

    hpel_lane #(.PIX_W(PIX_W)) u_lane (
      .mode     (mode_q),
      .rc       (rc_q),
      .cur_p    (in_row[g*PIX_W +: PIX_W]),
      .cur_q    (in_row_sh[g*PIX_W +: PIX_W]),
      .prev_p   (prev_p),
      .prev_hs  (prev_hs),
      .prev_lsb (prev_lsb),
      .pix      (pix),
      .hs       (hs),
      .lsb      (lsb)
    );

    // previous-row store: each reference row is fetched once
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_p   <= '0;
        prev_hs  <= '0;
        prev_lsb <= 1'b0;
      end else if (accept) begin
        prev_p   <= in_row[g*PIX_W +: PIX_W];
        prev_hs  <= hs;
        prev_lsb <= lsb;
      end
    end

    assign next_row[g*PIX_W +: PIX_W] = pix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_row   <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_row <= next_row;
    end
  end
endmodule

// File: rtl/hpel_checker.sv
module hpel_checker #(
  parameter int LANES = 8,
  parameter int ROWS  = 8,
  parameter int PIX_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   done,
  input logic                   busy,
  input logic [1:0]             mode_q,
  input logic [LANES*PIX_W-1:0] in_row,
  input logic [LANES*PIX_W-1:0] out_row
);
  localparam int CW = $clog2(ROWS + 2);
  logic [CW-1:0] out_cnt;

  always_ff @(posedge clk) begin
    if (rst || done) out_cnt <= '0;
    else if (out_valid) out_cnt <= out_cnt + 1'b1;
  end

  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  assert_copy_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == 2'd0) |-> out_row == $past(in_row));

  assert_out_follows_accept_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

  assert_row_limit_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_cnt < CW'(ROWS));

  assert_done_count_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> out_cnt == CW'(ROWS));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(out_valid)));

  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
endmodule

bind hpel_predictor hpel_checker #(.LANES(LANES), .ROWS(ROWS), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .done      (done),
  .busy      (busy),
  .mode_q    (mode_q),
  .in_row    (in_row),
  .out_row   (out_row)
);

// File: tb/tb_hpel_predictor.sv
module tb_hpel_predictor;
  localparam int LANES = 8;
  localparam int ROWS  = 8;
  localparam int PW    = 8;
  localparam int RW    = LANES * PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          rc_i = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [RW-1:0] in_row = '0;
  logic [RW-1:0] in_row_sh = '0;
  logic          out_valid;
  logic [RW-1:0] out_row;
  logic          done;
  logic          busy;

  always #2 clk = ~clk;

  hpel_predictor #(.LANES(LANES), .ROWS(ROWS), .PIX_W(PW)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode_i), .rnd_off(rc_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .in_row_sh(in_row_sh), .out_valid(out_valid), .out_row(out_row),
    .done(done), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [RW-1:0] got [0:15];
  int  ngot, ndone, last_out_cyc, done_cyc;
  bit  mon_clr = 0;

  always @(negedge clk) begin
    if (mon_clr) begin
      ngot = 0; ndone = 0; last_out_cyc = -10; done_cyc = -20;
    end else begin
      if (out_valid) begin
        if (ngot < 16) got[ngot] = out_row;
        ngot++;
        last_out_cyc = cyc;
      end
      if (done) begin
        ndone++;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pix(int seed, int r, int c);
    if (seed == 1) return 255;
    if (seed == 2) return 0;
    return (seed * 31 + r * 57 + c * c * 13 + r * c * 7) & 255;
  endfunction

  function automatic logic [RW-1:0] exprow(int md, int rc, int seed, int r);
    logic [RW-1:0] v;
    for (int c = 0; c < LANES; c++) begin
      int a, b, cc, d, res;
      a  = pix(seed, r, c);
      b  = pix(seed, r, c + 1);
      cc = pix(seed, r + 1, c);
      d  = pix(seed, r + 1, c + 1);
      case (md)
        0:       res = a;
        1:       res = (a + b + 1 - rc) >> 1;
        2:       res = (a + cc + 1 - rc) >> 1;
        default: res = (a + b + cc + d + 2 - rc) >> 2;
      endcase
      v[c*PW +: PW] = res[PW-1:0];
    end
    return v;
  endfunction

  // one directed scenario: drive a request, check every row, framing and done
  task automatic run_case(input int md, input int rc, input int seed,
                          input bit gap, input bit poke);
    int need, k;
    bit stalled;
    string req;
    need = (md >= 2) ? ROWS + 1 : ROWS;
    case (md)
      0: req = "R3";
      1: req = "R4";
      2: req = "R5";
      default: req = "R6";
    endcase
    @(negedge clk);
    mon_clr = 1;
    start = 1; mode_i = md[1:0]; rc_i = rc[0];
    @(negedge clk);
    mon_clr = 0;
    start = 0;
    if (poke) begin
      mode_i = md[1:0] ^ 2'd1;   // R10: inputs change after the request is taken
      rc_i   = ~rc[0];
    end
    k = 0; stalled = 0;
    while (k < need) begin
      if (gap && (k % 2 == 1) && !stalled) begin
        in_valid = 0;
        stalled = 1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after idle beat", {63'd0, out_valid}, 64'd0);
      end else begin
        bit acc;
        in_valid = 1;
        for (int c = 0; c < LANES; c++) begin
          in_row[c*PW +: PW]    = pix(seed, k, c);
          in_row_sh[c*PW +: PW] = pix(seed, k, c + 1);
        end
        start = (poke && k == 3);  // R2: start while busy must be ignored
        acc = in_ready;
        @(negedge clk);
        start = 0;
        if (acc) begin k++; stalled = 0; end
      end
    end
    in_valid = 0;
    for (int w = 0; w < 20 && ndone == 0; w++) @(negedge clk);
    @(negedge clk);
    chk(ngot == ROWS, "R7", "row count", 64'(ngot), 64'(ROWS));
    for (int r = 0; r < ROWS && r < ngot; r++) begin
      logic [RW-1:0] e;
      e = exprow(md, rc, seed, r);
      chk(got[r] === e, req, $sformatf("mode %0d rc %0d row %0d", md, rc, r), got[r], e);
    end
    chk(ndone == 1, "R8", "done pulse count", 64'(ndone), 64'd1);
    chk(done_cyc == last_out_cyc + 1, "R8", "done timing", 64'(done_cyc), 64'(last_out_cyc + 1));
    chk(busy == 1'b0, "R8", "busy after done", {63'd0, busy}, 64'd0);
    chk(in_ready == 1'b0, "R2", "in_ready when idle", {63'd0, in_ready}, 64'd0);
  endtask

  task automatic reset_test();
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done && !busy && !in_ready, "R1", "outputs in reset",
        {60'd0, out_valid, done, busy, in_ready}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !done && !busy && !in_ready, "R1", "outputs after reset",
        {60'd0, out_valid, done, busy, in_ready}, 64'd0);
  endtask

  initial begin
    reset_test();
    run_case(0, 0, 3, 0, 0);
    run_case(0, 1, 3, 1, 0);   // R3: rounding bit has no effect in copy
    run_case(1, 0, 5, 0, 0);
    run_case(1, 1, 5, 1, 1);
    run_case(2, 0, 7, 1, 0);
    run_case(2, 1, 1, 0, 0);
    run_case(3, 0, 9, 1, 1);
    run_case(3, 1, 2, 0, 0);
    run_case(3, 0, 1, 0, 0);   // R6: all-255 area, widest sum
    run_case(1, 0, 1, 0, 0);
    run_case(3, 1, 11, 0, 1);
    run_case(2, 0, 13, 0, 1);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule